// File: doc/BRIEF.md
# I2C Mode and Direction Controller

This block keeps the operating mode of a two-wire serial interface: master or slave, transmitting or receiving, whether reception stalls per byte, and a clock-select field. Software sets these fields through a one-cycle write strobe with an 8-bit data word and can read them back. The bit shifter, start/stop detector and baud divider sit outside. They report bus events to this block as single-cycle pulses, and the block adjusts the mode on its own in response.

Three bus events override software. A lost arbitration while mastering the two-wire format drops the block to slave receive. A receive overrun while mastering the clock-synchronous format also drops it to slave receive. An address byte that matches the local slave address with the read bit set turns a slave receiver into a slave transmitter. The block also drives a serial-clock output enable, times the data setup interval before each slave-transmit byte, and asks the shifter to stall reception when a held byte is still unread.

Top module: `i2c_mode_ctrl`

## Requirements
- R1: After reset every control field is 0, so `mode` is 00 (slave receive), `rd_data` is 0 and `scl_out_en`, `setup_cnt`, `setup_done` and `rx_stall` are 0.
- R2: A write with `wr_en` high loads the fields on the next clock edge. Field positions are: bit 0 master, bit 1 transmit, bit 2 receive hold, bits 7:4 clock select, and bit 3 reads 0. `mode` is {master, transmit}: 00 slave receive, 01 slave transmit, 10 master receive, 11 master transmit.
- R3: When `arb_lost` pulses with master = 1 and `sync_fmt` = 0, master and transmit are both cleared on the next edge. In any other state the pulse leaves the mode unchanged.
- R4: When `addr_valid` pulses in slave receive mode, and `addr_byte[7:1]` equals `own_addr` and `addr_byte[0]` is 1, transmit is set on the next edge. A wrong address, a 0 in bit 0, or any other mode leaves the mode unchanged.
- R5: When `overrun` pulses in master receive mode with `sync_fmt` = 1, master is cleared on the next edge. In any other state the pulse leaves the mode unchanged.
- R6: `scl_out_en` is 1 exactly when `sync_fmt` = 1 and master = 1.
- R7: A `byte_start` pulse in slave transmit mode loads `setup_cnt` with 10 when clock-select bit 7 is 0, or with 20 when it is 1. The counter then falls by one per cycle to 0. `setup_done` is high for the single cycle in which the count reaches 0. In other modes `byte_start` loads nothing and the counter reads 0.
- R8: `rx_stall` is 1 exactly when receive hold = 1, transmit = 0 and `rxbuf_full` = 1.
- R9: A write made while `frame_busy` = 1 holds the new transmit bit pending, while its other fields take effect at once. The pending value is applied on the first edge at which `frame_busy` is 0.
- R10: A bus event that changes the mode wins over a software write in the same cycle: the written master and transmit bits are discarded while the other written fields still load. Such an event also cancels any pending transmit write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read-back |
| sync_fmt | input | 1 | 1 = clock-synchronous format, 0 = two-wire format |
| frame_busy | input | 1 | A transfer frame is in progress |
| arb_lost | input | 1 | Arbitration-loss pulse |
| overrun | input | 1 | Receive-overrun pulse |
| addr_valid | input | 1 | Address byte received pulse |
| addr_byte | input | 8 | Address byte, bit 0 = read/write |
| own_addr | input | 7 | Local slave address |
| byte_start | input | 1 | Slave-transmit byte begins |
| rxbuf_full | input | 1 | Receive data register full and unread |
| mode | output | 2 | {master, transmit} |
| scl_out_en | output | 1 | Serial clock output enable |
| setup_cnt | output | 5 | Setup-time counter |
| setup_done | output | 1 | Setup interval elapsed strobe |
| rx_stall | output | 1 | Reception stall request |

## Verification
The collision that matters is a software write and a bus event landing in the same cycle. The bench provokes it by pulsing `arb_lost` together with a write that sets master and transmit. It also pulses an address match together with a write that clears transmit. In both cases it checks the read-back: the mode must follow the event, while the clock-select and hold fields from the same write still load. A second collision puts a bus event between a busy-time transmit write and the end of its frame. The bench then checks that the pending value never lands once the frame ends.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int CLK_SEL_W = 4;
  localparam int REG_W     = 8;

  typedef enum logic [1:0] {
    MODE_SLV_RX = 2'b00,
    MODE_SLV_TX = 2'b01,
    MODE_MST_RX = 2'b10,
    MODE_MST_TX = 2'b11
  } i2cm_mode_e;

  typedef struct packed {
    logic [CLK_SEL_W-1:0] clk_sel;
    logic                 rx_hold;
    logic                 xmit;
    logic                 master;
  } i2cm_ctrl_t;
endpackage

// File: rtl/i2cm_rst_sync.sv
module i2cm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/i2cm_event_qual.sv
module i2cm_event_qual #(
  parameter int ADDR_W = 7
) (
  input  logic              master,
  input  logic              xmit,
  input  logic              sync_fmt,
  input  logic              arb_lost,
  input  logic              overrun,
  input  logic              addr_valid,
  input  logic [ADDR_W:0]   addr_byte,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              hw_clr_both,
  output logic              hw_clr_master,
  output logic              hw_set_xmit
);
  logic addr_hit;

  always_comb begin
    addr_hit      = (addr_byte[ADDR_W:1] == own_addr) && addr_byte[0];
    hw_clr_both   = arb_lost && master && !sync_fmt;
    hw_clr_master = overrun && sync_fmt && master && !xmit;
    hw_set_xmit   = addr_valid && addr_hit && !master && !xmit;
  end
endmodule

// File: rtl/i2cm_ctrl_regs.sv
module i2cm_ctrl_regs
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  i2cm_ctrl_t wr_fields,
  input  logic       frame_busy,
  input  logic       hw_clr_both,
  input  logic       hw_clr_master,
  input  logic       hw_set_xmit,
  output i2cm_ctrl_t ctrl
);
  i2cm_ctrl_t ctrl_q, ctrl_n;
  logic       pend_q, pend_n;
  logic       pval_q, pval_n;
  logic       hw_ev, drain, upd;

  always_comb begin
    hw_ev  = hw_clr_both || hw_clr_master || hw_set_xmit;
    drain  = pend_q && !frame_busy;
    upd    = wr_en || hw_ev || drain;
    ctrl_n = ctrl_q;
    pend_n = pend_q;
    pval_n = pval_q;
    if (wr_en) begin
      ctrl_n.rx_hold = wr_fields.rx_hold;
      ctrl_n.clk_sel = wr_fields.clk_sel;
    end
    if (hw_ev) begin
      pend_n = 1'b0;
      if (hw_clr_both) begin
        ctrl_n.master = 1'b0;
        ctrl_n.xmit   = 1'b0;
      end
      if (hw_clr_master) ctrl_n.master = 1'b0;
      if (hw_set_xmit)   ctrl_n.xmit   = 1'b1;
    end else if (wr_en) begin
      ctrl_n.master = wr_fields.master;
      if (frame_busy) begin
        pend_n = 1'b1;
        pval_n = wr_fields.xmit;
      end else begin
        ctrl_n.xmit = wr_fields.xmit;
        pend_n      = 1'b0;
      end
    end else if (drain) begin
      ctrl_n.xmit = pval_q;
      pend_n      = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pend_q <= 1'b0;
      pval_q <= 1'b0;
    end else if (upd) begin
      ctrl_q <= ctrl_n;
      pend_q <= pend_n;
      pval_q <= pval_n;
    end
  end

  assign ctrl = ctrl_q;

  a_r10_hw_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
    hw_clr_both |=> (!ctrl_q.master && !ctrl_q.xmit));
  a_r4_match_sets_xmit: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set_xmit |=> ctrl_q.xmit);
  a_r9_busy_holds_xmit: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_busy && !hw_ev) |=> $stable(ctrl_q.xmit));
  a_r9_pending_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (drain && !hw_ev && !wr_en) |=> (!pend_q && ctrl_q.xmit == $past(pval_q)));
endmodule

// File: rtl/i2cm_setup_timer.sv
module i2cm_setup_timer #(
  parameter int SETUP_SHORT = 10,
  parameter int SETUP_LONG  = 20,
  parameter int CNT_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slv_tx,
  input  logic             byte_start,
  input  logic             long_sel,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             done_q, done_n;
  logic             load;

  always_comb begin
    load   = byte_start && slv_tx;
    done_n = slv_tx && !load && (cnt_q == CNT_W'(1));
    if (!slv_tx)                 cnt_n = '0;
    else if (load)               cnt_n = long_sel ? CNT_W'(SETUP_LONG) : CNT_W'(SETUP_SHORT);
    else if (cnt_q != '0)        cnt_n = cnt_q - CNT_W'(1);
    else                         cnt_n = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      done_q <= done_n;
    end
  end

  assign cnt  = cnt_q;
  assign done = done_q;

  a_r7_done_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cnt_q == '0));
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r7_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_start && slv_tx) |=> (cnt_q == CNT_W'(SETUP_SHORT) || cnt_q == CNT_W'(SETUP_LONG)));
endmodule

// File: rtl/i2c_mode_ctrl.sv
module i2c_mode_ctrl
  import i2cm_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SETUP_SHORT = 10,
  parameter int SETUP_LONG  = 20,
  localparam int CNT_W      = $clog2(SETUP_LONG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic              sync_fmt,
  input  logic              frame_busy,
  input  logic              arb_lost,
  input  logic              overrun,
  input  logic              addr_valid,
  input  logic [ADDR_W:0]   addr_byte,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              byte_start,
  input  logic              rxbuf_full,
  output logic [1:0]        mode,
  output logic              scl_out_en,
  output logic [CNT_W-1:0]  setup_cnt,
  output logic              setup_done,
  output logic              rx_stall
);
  localparam int F_MASTER  = 0;
  localparam int F_XMIT    = 1;
  localparam int F_HOLD    = 2;
  localparam int F_SPARE   = 3;
  localparam int F_CKS_LSB = 4;

  logic       rst_i_n;
  i2cm_ctrl_t wr_fields, ctrl;
  logic       hw_clr_both, hw_clr_master, hw_set_xmit;
  logic       slv_tx;
  logic       unused_wr_spare;

  i2cm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  always_comb begin
    wr_fields.master  = wr_data[F_MASTER];
    wr_fields.xmit    = wr_data[F_XMIT];
    wr_fields.rx_hold = wr_data[F_HOLD];
    wr_fields.clk_sel = wr_data[F_CKS_LSB +: CLK_SEL_W];
  end
  assign unused_wr_spare = wr_data[F_SPARE];

  i2cm_event_qual #(.ADDR_W(ADDR_W)) u_qual (
    .master        (ctrl.master),
    .xmit          (ctrl.xmit),
    .sync_fmt      (sync_fmt),
    .arb_lost      (arb_lost),
    .overrun       (overrun),
    .addr_valid    (addr_valid),
    .addr_byte     (addr_byte),
    .own_addr      (own_addr),
    .hw_clr_both   (hw_clr_both),
    .hw_clr_master (hw_clr_master),
    .hw_set_xmit   (hw_set_xmit)
  );

  i2cm_ctrl_regs u_regs (
    .clk           (clk),
    .rst_n         (rst_i_n),
    .wr_en         (wr_en),
    .wr_fields     (wr_fields),
    .frame_busy    (frame_busy),
    .hw_clr_both   (hw_clr_both),
    .hw_clr_master (hw_clr_master),
    .hw_set_xmit   (hw_set_xmit),
    .ctrl          (ctrl)
  );

  assign slv_tx = (i2cm_mode_e'({ctrl.master, ctrl.xmit}) == MODE_SLV_TX);

  i2cm_setup_timer #(
    .SETUP_SHORT (SETUP_SHORT),
    .SETUP_LONG  (SETUP_LONG),
    .CNT_W       (CNT_W)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .slv_tx     (slv_tx),
    .byte_start (byte_start),
    .long_sel   (ctrl.clk_sel[CLK_SEL_W-1]),
    .cnt        (setup_cnt),
    .done       (setup_done)
  );

  always_comb begin
    rd_data                           = '0;
    rd_data[F_MASTER]                 = ctrl.master;
    rd_data[F_XMIT]                   = ctrl.xmit;
    rd_data[F_HOLD]                   = ctrl.rx_hold;
    rd_data[F_CKS_LSB +: CLK_SEL_W]   = ctrl.clk_sel;
    mode       = {ctrl.master, ctrl.xmit};
    scl_out_en = sync_fmt && ctrl.master;
    rx_stall   = ctrl.rx_hold && !ctrl.xmit && rxbuf_full;
  end

  a_r3_arb_to_slave_rx: assert property (@(posedge clk) disable iff (!rst_i_n)
    (arb_lost && !sync_fmt && mode[1]) |=> (mode == 2'b00));
  a_r5_overrun_to_slave_rx: assert property (@(posedge clk) disable iff (!rst_i_n)
    (overrun && sync_fmt && mode == 2'b10) |=> (mode == 2'b00));
endmodule

// File: tb/tb_i2c_mode_ctrl.sv
module tb_i2c_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, sync_fmt, frame_busy, arb_lost, overrun, addr_valid;
  logic       byte_start, rxbuf_full;
  logic [7:0] wr_data, rd_data, addr_byte;
  logic [6:0] own_addr;
  logic [1:0] mode;
  logic       scl_out_en, setup_done, rx_stall;
  logic [4:0] setup_cnt;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;
  bit ended  = 0;

  always #4 clk = ~clk;

  i2c_mode_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .sync_fmt(sync_fmt), .frame_busy(frame_busy), .arb_lost(arb_lost),
    .overrun(overrun), .addr_valid(addr_valid), .addr_byte(addr_byte),
    .own_addr(own_addr), .byte_start(byte_start), .rxbuf_full(rxbuf_full),
    .mode(mode), .scl_out_en(scl_out_en), .setup_cnt(setup_cnt),
    .setup_done(setup_done), .rx_stall(rx_stall)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 50000);
      finish_run();
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; arb_lost = 0; overrun = 0; addr_valid = 0; byte_start = 0;
  endtask

  task automatic write(logic [7:0] v);
    wr_en = 1; wr_data = v;
    tick();
  endtask

  initial begin
    rst_n = 0; wr_en = 0; wr_data = 0; sync_fmt = 0; frame_busy = 0;
    arb_lost = 0; overrun = 0; addr_valid = 0; addr_byte = 0;
    own_addr = 7'h5A; byte_start = 0; rxbuf_full = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 rd_data", rd_data, 0);
    chk("R1 mode", mode, 0);
    chk("R1 scl_out_en", scl_out_en, 0);
    chk("R1 setup_cnt", setup_cnt, 0);
    chk("R1 setup_done", setup_done, 0);
    chk("R1 rx_stall", rx_stall, 0);

    // R2 / R6 write sweep over every data word
    for (int v = 0; v < 256; v++) begin
      sync_fmt = v[3];
      write(8'(v));
      chk("R2 read-back", rd_data, v & 8'hF7);
      chk("R2 mode", mode, ((v & 1) << 1) | ((v >> 1) & 1));
      chk("R6 scl_out_en", scl_out_en, ((v >> 3) & 1) & (v & 1));
    end

    // R3 / R4 / R5 event sweep over every mode and format
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 2; s++) begin
        for (int ev = 0; ev < 5; ev++) begin
          int mst, trs, exp_mode;
          mst = m >> 1; trs = m & 1;
          sync_fmt = 1'(s);
          write(8'((mst) | (trs << 1)));
          exp_mode = m;
          case (ev)
            0: begin arb_lost = 1; if (s == 0 && mst == 1) exp_mode = 0; end
            1: begin overrun = 1; if (s == 1 && m == 2) exp_mode = 0; end
            2: begin addr_valid = 1; addr_byte = 8'hB5; if (m == 0) exp_mode = 1; end
            3: begin addr_valid = 1; addr_byte = 8'hB7; end
            default: begin addr_valid = 1; addr_byte = 8'hB4; end
          endcase
          tick();
          if (ev == 0)      chk("R3 arbitration loss", mode, exp_mode);
          else if (ev == 1) chk("R5 overrun", mode, exp_mode);
          else              chk("R4 address match", mode, exp_mode);
        end
      end
    end
    sync_fmt = 0;

    // R10 hardware beats a same-cycle write
    write(8'h03);
    wr_en = 1; wr_data = 8'h93; arb_lost = 1;
    tick();
    chk("R10 arb vs write", rd_data, 8'h90);
    write(8'h00);
    wr_en = 1; wr_data = 8'h04; addr_valid = 1; addr_byte = 8'hB5;
    tick();
    chk("R10 match vs write", rd_data, 8'h06);

    // R9 pending transmit write
    write(8'h00);
    frame_busy = 1;
    write(8'h52);
    chk("R9 held while busy", rd_data, 8'h50);
    tick(); tick();
    chk("R9 still held", rd_data, 8'h50);
    frame_busy = 0;
    tick();
    chk("R9 applied at frame end", rd_data, 8'h52);

    // R10 event cancels a pending write
    write(8'h00);
    frame_busy = 1;
    write(8'h03);
    chk("R9 master applies at once", rd_data, 8'h01);
    arb_lost = 1;
    tick();
    chk("R10 cleared by arb", rd_data, 8'h00);
    frame_busy = 0;
    tick();
    chk("R10 pending cancelled", rd_data, 8'h00);

    // R7 setup timer, both lengths
    for (int l = 0; l < 2; l++) begin
      int n;
      n = (l == 1) ? 20 : 10;
      write(l == 1 ? 8'h82 : 8'h02);
      byte_start = 1;
      tick();
      chk("R7 load", setup_cnt, n);
      chk("R7 no early done", setup_done, 0);
      for (int i = 1; i <= n + 1; i++) begin
        tick();
        chk("R7 count", setup_cnt, (i <= n) ? n - i : 0);
        chk("R7 done strobe", setup_done, (i == n) ? 1 : 0);
      end
    end
    write(8'h80);
    byte_start = 1;
    tick();
    chk("R7 no load outside slave tx", setup_cnt, 0);

    // R8 stall sweep
    for (int k = 0; k < 8; k++) begin
      int h, t, f;
      h = k & 1; t = (k >> 1) & 1; f = (k >> 2) & 1;
      write(8'((h << 2) | (t << 1)));
      rxbuf_full = 1'(f);
      #1;
      chk("R8 rx_stall", rx_stall, h & (1 - t) & f);
    end
    rxbuf_full = 0;

    finish_run();
  end
endmodule